// File: doc/BRIEF.md
# Asynchronous Memory Bank Access Sequencer

The block generates the three strobes of an external asynchronous memory: output enable, read strobe and write strobe. A client starts an access with a one-cycle request that carries a direction and a bank number. The sequencer then steps through a fixed series of phases. Output enable rises first for a setup interval. The read or write strobe is then held for the access interval, which an external ready input can extend. Output enable stays up for a hold interval after the strobe drops. A one-cycle done pulse ends the access. When a read is followed by a write to the same bank, or by a read to another bank, a turnaround gap is placed before the next setup.

Timing comes from a 32-bit control word that software writes as a whole. The word holds one 16-bit half per bank: the low half serves bank 0 and the high half serves bank 1. The sequencer copies the selected half when it accepts a request, so the running access is fixed. The state machine has seven states:

- IDLE: accepts a request.
- GAP: turnaround.
- SETUP: output enable only.
- ACCESS: strobe asserted, counting.
- RDYWAIT: strobe held, polling ready.
- HOLD: output enable only, after the strobe.
- DONE: pulse, back to IDLE.

The transitions are:

- IDLE→GAP or IDLE→SETUP on acceptance.
- GAP→SETUP when the gap count expires.
- SETUP→ACCESS when the setup count expires.
- ACCESS→HOLD, ACCESS→DONE or ACCESS→RDYWAIT at the end of the access count.
- RDYWAIT→HOLD or RDYWAIT→DONE on the completing ready level.
- HOLD→DONE when the hold count expires.
- DONE→IDLE.

Top module: `async_bank_seq`

## Requirements
- R1: After reset the control word reads 0xFFC2FFC2, all strobes and done are low and req_ready is high.
- R2: Each 16-bit half is laid out as follows: [15:12] write time, [11:8] read time, [7:6] hold, [5:4] setup, [3:2] gap, [1] ready polarity, [0] ready enable. Bits [15:0] time bank 0 and bits [31:16] time bank 1.
- R3: The setup phase keeps output enable high with both strobes low for 1, 2 or 3 cycles for codes 1 to 3, and for 4 cycles for code 0.
- R4: The access phase holds the read strobe for the read-time code, or the write strobe for the write-time code, from 1 to 15 cycles. A code of 0 gives 1 cycle.
- R5: The hold phase keeps output enable high with both strobes low for 0 to 3 cycles, equal to the hold code.
- R6: Done is high for exactly one cycle. That cycle is the first cycle with output enable low after the access, and the block is back in idle on the following cycle.
- R7: With ready enable at 0, the ready input has no effect on the strobe length.
- R8: With ready enable at 1, ready is sampled on the last counted access cycle and on every cycle after it. The strobe stays asserted until the completing level is sampled.
- R9: Ready polarity 1 completes on ready high. Ready polarity 0 completes on ready low.
- R10: After a read from bank B, a following write to B or a read to another bank waits for a gap before its setup. The gap uses the gap code of B as it was at the time of that read: codes 1 to 3 give 1 to 3 cycles and code 0 gives 4 cycles. Any other pairing starts setup on the cycle after acceptance.
- R11: req_ready is high only in idle. A request is accepted only on a clock edge where req_valid and req_ready are both high. From acceptance until done, req_ready stays low.
- R12: A control word written during an access does not change the timing of that access.
- R13: The read and write strobes are never high together, and neither is ever high without output enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write enable for the control word |
| cfg_wdata | input | 32 | New control word |
| cfg_rdata | output | 32 | Current control word |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 1 | Target bank |
| req_ready | output | 1 | Block can accept a request |
| mem_ardy | input | 1 | Ready input from the memory |
| mem_oe | output | 1 | Output enable, active high |
| mem_rd | output | 1 | Read strobe, active high |
| mem_wr | output | 1 | Write strobe, active high |
| done | output | 1 | Access complete pulse |

## Verification
Each access is measured by cycle count and split into four parts: the cycles before output enable, the setup cycles, the strobe cycles and the hold cycles. Every request pattern is chosen so that a wrong field, bank half or code mapping shows up as a distinct count. Read/write pairings across the two banks separate the gap cases: same bank after a read, other bank after a read, and pairings that take no gap. Ready-release delays shorter and longer than the programmed access time, with both polarities and with ready enable off, tell the countdown apart from the ready extension. A control-word rewrite in the middle of an access, and a gap code changed between a read and the next request, show whether the block uses its snapshot or the live word.

// File: rtl/abs_pkg.sv
package abs_pkg;

    localparam int HALF_W = 16;
    localparam int CNT_W  = 4;

    typedef struct packed {
        logic [3:0] wr_time;
        logic [3:0] rd_time;
        logic [1:0] hold;
        logic [1:0] setup;
        logic [1:0] gap;
        logic       rdy_pol;
        logic       rdy_en;
    } bank_timing_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_SETUP,
        ST_ACCESS,
        ST_RDYWAIT,
        ST_HOLD,
        ST_DONE
    } seq_state_t;

    // 2-bit code where 0 stands for four cycles
    function automatic logic [CNT_W-1:0] wrap4_len(input logic [1:0] code);
        return (code == 2'd0) ? CNT_W'(4) : CNT_W'(code);
    endfunction

    // 4-bit access code where 0 is promoted to one cycle
    function automatic logic [CNT_W-1:0] access_len(input logic [3:0] code);
        return (code == 4'd0) ? CNT_W'(1) : CNT_W'(code);
    endfunction

endpackage

// File: rtl/abs_cfg_reg.sv
module abs_cfg_reg #(
    parameter int          W         = 32,
    parameter logic [W-1:0] RESET_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= RESET_VAL;
        else if (we)
            q <= wdata;
    end
endmodule

// File: rtl/abs_bank_sel.sv
module abs_bank_sel
    import abs_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int BANK_W    = 1
) (
    input  logic [NUM_BANKS*HALF_W-1:0] word,
    input  logic [BANK_W-1:0]           bank,
    output bank_timing_t                sel
);
    bank_timing_t halves [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_half
        assign halves[b] = bank_timing_t'(word[b*HALF_W +: HALF_W]);
    end

    always_comb begin
        sel = halves[0];
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (BANK_W'(b) == bank)
                sel = halves[b];
        end
    end
endmodule

// File: rtl/abs_phase_cnt.sv
module abs_phase_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - W'(1);
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/async_bank_seq.sv
module async_bank_seq
    import abs_pkg::*;
#(
    parameter int              NUM_BANKS  = 2,
    parameter logic [HALF_W-1:0] HALF_RESET = 16'hFFC2,
    localparam int             BANK_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int             CFG_W      = NUM_BANKS * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [BANK_W-1:0] req_bank,
    output logic              req_ready,
    input  logic              mem_ardy,
    output logic              mem_oe,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              done
);
    localparam logic [CFG_W-1:0] CFG_RESET = {NUM_BANKS{HALF_RESET}};

    seq_state_t   state_q, state_d;
    bank_timing_t live_tim, tim_q;
    logic         wr_q;
    logic         last_rd_q;
    logic [BANK_W-1:0] last_bank_q;
    logic [1:0]   last_gap_q;

    logic             cnt_load, cnt_zero;
    logic [CNT_W-1:0] cnt_val;
    logic             accept, need_gap, rdy_ok;

    abs_cfg_reg #(.W(CFG_W), .RESET_VAL(CFG_RESET)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .q     (cfg_rdata)
    );

    abs_bank_sel #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_sel (
        .word (cfg_rdata),
        .bank (req_bank),
        .sel  (live_tim)
    );

    abs_phase_cnt #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .zero     (cnt_zero)
    );

    assign accept   = (state_q == ST_IDLE) && req_valid;
    assign need_gap = last_rd_q &&
                      (req_write ? (req_bank == last_bank_q) : (req_bank != last_bank_q));
    assign rdy_ok   = !tim_q.rdy_en || (mem_ardy == tim_q.rdy_pol);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Snapshot of the accepted request and turnaround history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tim_q       <= bank_timing_t'(HALF_RESET);
            wr_q        <= 1'b0;
            last_rd_q   <= 1'b0;
            last_bank_q <= '0;
            last_gap_q  <= 2'd0;
        end else if (accept) begin
            tim_q       <= live_tim;
            wr_q        <= req_write;
            last_rd_q   <= !req_write;
            last_bank_q <= req_bank;
            last_gap_q  <= live_tim.gap;
        end
    end

    // Next state and phase counter loading
    always_comb begin
        state_d  = state_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    cnt_load = 1'b1;
                    if (need_gap) begin
                        state_d = ST_GAP;
                        cnt_val = wrap4_len(last_gap_q) - CNT_W'(1);
                    end else begin
                        state_d = ST_SETUP;
                        cnt_val = wrap4_len(live_tim.setup) - CNT_W'(1);
                    end
                end
            end
            ST_GAP: begin
                if (cnt_zero) begin
                    state_d  = ST_SETUP;
                    cnt_load = 1'b1;
                    cnt_val  = wrap4_len(tim_q.setup) - CNT_W'(1);
                end
            end
            ST_SETUP: begin
                if (cnt_zero) begin
                    state_d  = ST_ACCESS;
                    cnt_load = 1'b1;
                    cnt_val  = access_len(wr_q ? tim_q.wr_time : tim_q.rd_time) - CNT_W'(1);
                end
            end
            ST_ACCESS, ST_RDYWAIT: begin
                if (state_q == ST_RDYWAIT || cnt_zero) begin
                    if (!rdy_ok) begin
                        state_d = ST_RDYWAIT;
                    end else if (tim_q.hold == 2'd0) begin
                        state_d = ST_DONE;
                    end else begin
                        state_d  = ST_HOLD;
                        cnt_load = 1'b1;
                        cnt_val  = CNT_W'(tim_q.hold) - CNT_W'(1);
                    end
                end
            end
            ST_HOLD: begin
                if (cnt_zero)
                    state_d = ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        req_ready = 1'b0;
        mem_oe    = 1'b0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_GAP:   ;
            ST_SETUP, ST_HOLD: mem_oe = 1'b1;
            ST_ACCESS, ST_RDYWAIT: begin
                mem_oe = 1'b1;
                mem_rd = !wr_q;
                mem_wr = wr_q;
            end
            ST_DONE:  done = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/abs_seq_chk.sv
module abs_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic mem_oe,
    input logic mem_rd,
    input logic mem_wr,
    input logic done
);
    // R13
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R13
    strobe_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> mem_oe);

    // R3
    setup_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_rd) || $rose(mem_wr)) |-> $past(mem_oe));

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    oe_fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe) |-> done);

    // R11
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_oe && !done));
endmodule

bind async_bank_seq abs_seq_chk u_abs_seq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .mem_oe    (mem_oe),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .done      (done)
);

// File: tb/tb_async_bank_seq.sv
module tb_async_bank_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0, req_write = 1'b0, req_bank = 1'b0;
    logic        req_ready, mem_ardy = 1'b0;
    logic        mem_oe, mem_rd, mem_wr, done;

    always #2 clk = ~clk;

    async_bank_seq dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_write(req_write),
        .req_bank(req_bank), .req_ready(req_ready), .mem_ardy(mem_ardy),
        .mem_oe(mem_oe), .mem_rd(mem_rd), .mem_wr(mem_wr), .done(done)
    );

    int n_chk = 0, n_fail = 0;
    logic finished = 1'b0;
    logic [31:0] cur_cfg = 32'hFFC2FFC2;
    logic        m_last_rd = 1'b0, m_last_bank = 1'b0;
    logic [1:0]  m_last_gap = 2'd0;

    // {cfg, write, bank, ready release cycle}
    localparam logic [37:0] VEC [8] = '{
        {32'h5125235A, 1'b0, 1'b0, 4'd7},
        {32'h5125235A, 1'b1, 1'b1, 4'd0},
        {32'h5125235A, 1'b0, 1'b1, 4'd8},
        {32'h5125235A, 1'b0, 1'b0, 4'd0},
        {32'h51250FC3, 1'b1, 1'b0, 4'd3},
        {32'h51250FC3, 1'b0, 1'b0, 4'd0},
        {32'h51250FC3, 1'b1, 1'b0, 4'd2},
        {32'hF0BE0FC3, 1'b0, 1'b1, 4'd9}
    };

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        cur_cfg = v;
    endtask

    task automatic run_access(input logic wr, input logic bank, input int rdy_after,
                              input logic mid_we, input logic [31:0] mid_cfg);
        logic [15:0] hw;
        int e_pre, e_su, e_ac, e_ho, a;
        int pre, su, ac, ho, busy_bad, guard;
        logic pol, seen_oe;
        hw = bank ? cur_cfg[31:16] : cur_cfg[15:0];
        e_su = (hw[5:4] == 0) ? 4 : int'(hw[5:4]);
        a = wr ? int'(hw[15:12]) : int'(hw[11:8]);
        if (a == 0) a = 1;
        pol = hw[1];
        e_ac = (hw[0] && rdy_after > a) ? rdy_after : a;
        e_ho = int'(hw[7:6]);
        e_pre = 0;
        if (m_last_rd && (wr ? bank == m_last_bank : bank != m_last_bank))
            e_pre = (m_last_gap == 0) ? 4 : int'(m_last_gap);
        m_last_rd = !wr; m_last_bank = bank; m_last_gap = hw[3:2];

        pre = 0; su = 0; ac = 0; ho = 0; busy_bad = 0; guard = 0; seen_oe = 1'b0;
        mem_ardy = (rdy_after == 0) ? pol : ~pol;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_bank = bank;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done && guard < 200) begin
            guard++;
            if (req_ready) busy_bad++;
            if (cfg_we) cfg_we = 1'b0;
            if (!mem_oe && !seen_oe) pre++;
            else if (mem_oe) begin
                seen_oe = 1'b1;
                if (mem_rd || mem_wr) begin
                    ac++;
                    if ((wr && !mem_wr) || (!wr && !mem_rd)) busy_bad++;
                    if (mid_we && ac == 1) begin
                        cfg_we = 1'b1; cfg_wdata = mid_cfg;
                    end
                end else if (ac == 0) su++;
                else ho++;
            end
            mem_ardy = (ac >= rdy_after) ? pol : ~pol;
            @(negedge clk);
        end
        if (cfg_we) cfg_we = 1'b0;
        if (mid_we) cur_cfg = mid_cfg;
        check("R10 gap cycles before output enable", pre, e_pre);
        check("R3 R2 setup cycles", su, e_su);
        check("R4 R7 R8 R9 strobe cycles", ac, e_ac);
        check("R5 hold cycles", ho, e_ho);
        check("R11 req_ready low and correct strobe while busy", busy_bad, 0);
        check("R6 done with output enable low", int'(done && !mem_oe), 1);
        @(negedge clk);
        check("R6 done one cycle then idle", int'({done, req_ready}), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 control word reset value", int'(cfg_rdata == 32'hFFC2FFC2), 1);
        check("R1 strobes low", int'({mem_oe, mem_rd, mem_wr, done}), 0);
        check("R1 req_ready high", int'(req_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        // reset timing on bank 1, ready ignored (R7)
        run_access(1'b0, 1'b1, 12, 1'b0, '0);
        for (int i = 0; i < 8; i++) begin
            if (VEC[i][37:6] != cur_cfg) write_cfg(VEC[i][37:6]);
            run_access(VEC[i][5], VEC[i][4], int'(VEC[i][3:0]), 1'b0, '0);
        end
        // R12 mid-access rewrite must not alter the running access
        write_cfg(32'h5125235A);
        run_access(1'b1, 1'b0, 0, 1'b1, 32'h0F0F0F0F);
        check("R12 new word visible after access", int'(cfg_rdata == 32'h0F0F0F0F), 1);
        // R4 zero write code promoted to one cycle, R10 no gap after write
        write_cfg(32'h00000000);
        run_access(1'b1, 1'b1, 0, 1'b0, '0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule